// File: doc/BRIEF.md
# Overlay Window Command Sequencer

This block sits on the host side of a memory device that is controlled through a window of registers. It takes one request, made of a command code, a wide target address, an optional length and an optional data word. It turns the request into an ordered series of single-word writes on a 16-bit memory-mapped bus and closes the series with an execute write. It then reads the device status register until the ready bit comes up, and it reports completion with a one-cycle pulse. Along with the pulse it gives a failure flag, a timeout flag, the raw status word and a decoded two-bit region program code.

Each bus access is a one-cycle strobe carrying an address and, for writes, data. The sequencer issues nothing further until the bus acknowledges that access. It takes a new request only while idle. Polling stops after a parameterized number of not-ready reads, and the command then completes with a timeout.

Top module: `ovl_cmd_seq`

## Requirements
- R1: After reset the block is idle: `req_ready_o` is 1, `bus_wr_o`, `bus_rd_o` and `done_o` are 0.
- R2: Every command begins with exactly these writes in this order: the command code to offset 0x80, the low address half to 0x88, then the high address half to 0x8A.
- R3: When the requested length is nonzero, the low count half is written to 0x90 and then the high count half to 0x92, directly after the address writes. When the length is zero, neither offset is written.
- R4: When `req_has_data_i` is 1, the data word is written to 0x84 after any count writes and before the execute write. Otherwise 0x84 is not written.
- R5: The final write of every command is the value 0x0001 to offset 0xC0.
- R6: A wide value is split at the bus width: the low register gets the value modulo 2^BUS_W and the high register gets the value shifted right by BUS_W.
- R7: Every strobe lasts one cycle, `bus_wr_o` and `bus_rd_o` are never high together, and no new strobe is issued before the previous access has been acknowledged.
- R8: After the execute write is acknowledged, the block reads offset 0xCC until a returned word has bit 7 set. It then pulses `done_o` high for exactly one cycle.
- R9: On normal completion, `status_o` holds the raw final status word and `fail_o` is 1 exactly when that word has any bit of mask 0x133A set. `timeout_o` is 0.
- R10: `region_o` encodes bits 9:8 of the reported status by priority: 3 when both bits are 1, else 2 when bit 9 is 1, else 1 when bit 8 is 1, else 0.
- R11: If MAX_POLLS reads in a row return bit 7 clear, polling stops and the command completes with `timeout_o`=1 and `fail_o`=1. `status_o` then holds the last word read, and `region_o` is derived from it.
- R12: A request is taken only while `req_ready_o` is 1, which holds only in idle. A `req_valid_i` raised while a command is in progress causes no bus activity, either then or afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Idle, request can be taken |
| req_code_i | input | BUS_W | Command code |
| req_addr_i | input | CMD_ADDR_W | Target address |
| req_len_i | input | LEN_W | Length, zero for none |
| req_has_data_i | input | 1 | Data word accompanies request |
| req_data_i | input | BUS_W | Data word |
| bus_wr_o | output | 1 | Write strobe |
| bus_rd_o | output | 1 | Read strobe |
| bus_addr_o | output | ADDR_W | Register offset |
| bus_wdata_o | output | BUS_W | Write data |
| bus_ack_i | input | 1 | Access acknowledge |
| bus_rdata_i | input | BUS_W | Read data, valid with acknowledge |
| done_o | output | 1 | Completion pulse |
| fail_o | output | 1 | Error or timeout on last command |
| timeout_o | output | 1 | Last command hit the poll limit |
| status_o | output | BUS_W | Raw status word of last command |
| region_o | output | 2 | Decoded region program code |

## Verification
The bench covers the four combinations of zero or nonzero length and present or absent data. A sequencer that tested the wrong field would add or skip count or data writes, which shows up as a wrong write count or a wrong offset in the log. A length whose low half is zero but whose high half is not catches a design that decides on the low half alone, because that design drops the count writes. The status cases set each region pattern and error bits both inside and outside the mask, so a wrong priority or mask changes `region_o` or `fail_o`. The device is held busy past the poll limit to catch off-by-one read counts, and a request is raised mid-command to catch a sequencer that starts again.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

  typedef enum logic [2:0] {
    STEP_CODE,
    STEP_ADDR_L,
    STEP_ADDR_H,
    STEP_CNT_L,
    STEP_CNT_H,
    STEP_DATA,
    STEP_EXEC,
    STEP_POLL
  } step_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT
  } state_e;

  localparam logic [7:0] OFF_CODE   = 8'h80;
  localparam logic [7:0] OFF_DATA   = 8'h84;
  localparam logic [7:0] OFF_ADDR_L = 8'h88;
  localparam logic [7:0] OFF_ADDR_H = 8'h8A;
  localparam logic [7:0] OFF_CNT_L  = 8'h90;
  localparam logic [7:0] OFF_CNT_H  = 8'h92;
  localparam logic [7:0] OFF_EXEC   = 8'hC0;
  localparam logic [7:0] OFF_STAT   = 8'hCC;

  localparam logic [15:0] ERR_MASK  = 16'h133A;
  localparam logic [15:0] EXEC_VAL  = 16'h0001;
  localparam int          RDY_BIT   = 7;
  localparam int          REG_LO    = 8;
  localparam int          REG_HI    = 9;

endpackage

// File: rtl/ovl_step_ctrl.sv
module ovl_step_ctrl
  import ovl_pkg::*;
(
  input  step_e       step_i,
  input  logic        len_nz_i,
  input  logic        has_data_i,
  output step_e       next_o,
  output logic [7:0]  off_o,
  output logic        is_read_o
);

  always_comb begin
    next_o = STEP_POLL;
    unique case (step_i)
      STEP_CODE:   next_o = STEP_ADDR_L;
      STEP_ADDR_L: next_o = STEP_ADDR_H;
      STEP_ADDR_H: next_o = len_nz_i ? STEP_CNT_L : (has_data_i ? STEP_DATA : STEP_EXEC);
      STEP_CNT_L:  next_o = STEP_CNT_H;
      STEP_CNT_H:  next_o = has_data_i ? STEP_DATA : STEP_EXEC;
      STEP_DATA:   next_o = STEP_EXEC;
      STEP_EXEC:   next_o = STEP_POLL;
      STEP_POLL:   next_o = STEP_POLL;
      default:     next_o = STEP_POLL;
    endcase
  end

  always_comb begin
    off_o = OFF_STAT;
    unique case (step_i)
      STEP_CODE:   off_o = OFF_CODE;
      STEP_ADDR_L: off_o = OFF_ADDR_L;
      STEP_ADDR_H: off_o = OFF_ADDR_H;
      STEP_CNT_L:  off_o = OFF_CNT_L;
      STEP_CNT_H:  off_o = OFF_CNT_H;
      STEP_DATA:   off_o = OFF_DATA;
      STEP_EXEC:   off_o = OFF_EXEC;
      STEP_POLL:   off_o = OFF_STAT;
      default:     off_o = OFF_STAT;
    endcase
  end

  assign is_read_o = (step_i == STEP_POLL);

endmodule

// File: rtl/ovl_word_split.sv
module ovl_word_split #(
  parameter int VAL_W = 32,
  parameter int BUS_W = 16
) (
  input  logic [VAL_W-1:0] val_i,
  output logic [BUS_W-1:0] lo_o,
  output logic [BUS_W-1:0] hi_o
);

  generate
    if (VAL_W > BUS_W) begin : g_wide
      assign lo_o = BUS_W'(val_i);
      assign hi_o = BUS_W'(val_i >> BUS_W);
    end else begin : g_narrow
      assign lo_o = BUS_W'(val_i);
      assign hi_o = '0;
    end
  endgenerate

endmodule

// File: rtl/ovl_status_eval.sv
module ovl_status_eval
  import ovl_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic [BUS_W-1:0] word_i,
  output logic             ready_o,
  output logic             err_o,
  output logic [1:0]       region_o
);

  localparam logic [BUS_W-1:0] MASK_W = BUS_W'(ERR_MASK);

  assign ready_o = word_i[RDY_BIT];
  assign err_o   = |(word_i & MASK_W);

  // pattern 11 wins, then the upper bit, then the lower bit
  always_comb begin
    if (word_i[REG_HI] && word_i[REG_LO]) region_o = 2'd3;
    else if (word_i[REG_HI])              region_o = 2'd2;
    else if (word_i[REG_LO])              region_o = 2'd1;
    else                                  region_o = 2'd0;
  end

endmodule

// File: rtl/ovl_cmd_seq.sv
module ovl_cmd_seq
  import ovl_pkg::*;
#(
  parameter int BUS_W      = 16,
  parameter int ADDR_W     = 8,
  parameter int CMD_ADDR_W = 32,
  parameter int LEN_W      = 32,
  parameter int MAX_POLLS  = 4096
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  output logic                  req_ready_o,
  input  logic [BUS_W-1:0]      req_code_i,
  input  logic [CMD_ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]      req_len_i,
  input  logic                  req_has_data_i,
  input  logic [BUS_W-1:0]      req_data_i,
  output logic                  bus_wr_o,
  output logic                  bus_rd_o,
  output logic [ADDR_W-1:0]     bus_addr_o,
  output logic [BUS_W-1:0]      bus_wdata_o,
  input  logic                  bus_ack_i,
  input  logic [BUS_W-1:0]      bus_rdata_i,
  output logic                  done_o,
  output logic                  fail_o,
  output logic                  timeout_o,
  output logic [BUS_W-1:0]      status_o,
  output logic [1:0]            region_o
);

  localparam int POLL_CW = $clog2(MAX_POLLS + 1);
  localparam logic [POLL_CW-1:0] POLL_LAST = POLL_CW'(MAX_POLLS - 1);

  state_e                 state_q;
  step_e                  step_q;
  step_e                  step_nxt;
  logic [BUS_W-1:0]       code_q;
  logic [CMD_ADDR_W-1:0]  addr_q;
  logic [LEN_W-1:0]       len_q;
  logic                   has_data_q;
  logic [BUS_W-1:0]       data_q;
  logic [POLL_CW-1:0]     poll_cnt_q;
  logic                   done_q;
  logic                   fail_q;
  logic                   tmo_q;
  logic [BUS_W-1:0]       stat_q;
  logic [1:0]             region_q;

  logic [7:0]             step_off;
  logic                   step_rd;
  logic [BUS_W-1:0]       addr_lo, addr_hi, len_lo, len_hi;
  logic                   st_ready, st_err;
  logic [1:0]             st_region;
  logic                   len_nz;

  assign len_nz = |len_q;

  ovl_step_ctrl u_step (
    .step_i     (step_q),
    .len_nz_i   (len_nz),
    .has_data_i (has_data_q),
    .next_o     (step_nxt),
    .off_o      (step_off),
    .is_read_o  (step_rd)
  );

  ovl_word_split #(.VAL_W(CMD_ADDR_W), .BUS_W(BUS_W)) u_addr_split (
    .val_i (addr_q),
    .lo_o  (addr_lo),
    .hi_o  (addr_hi)
  );

  ovl_word_split #(.VAL_W(LEN_W), .BUS_W(BUS_W)) u_len_split (
    .val_i (len_q),
    .lo_o  (len_lo),
    .hi_o  (len_hi)
  );

  ovl_status_eval #(.BUS_W(BUS_W)) u_eval (
    .word_i   (bus_rdata_i),
    .ready_o  (st_ready),
    .err_o    (st_err),
    .region_o (st_region)
  );

  always_comb begin
    bus_wdata_o = '0;
    unique case (step_q)
      STEP_CODE:   bus_wdata_o = code_q;
      STEP_ADDR_L: bus_wdata_o = addr_lo;
      STEP_ADDR_H: bus_wdata_o = addr_hi;
      STEP_CNT_L:  bus_wdata_o = len_lo;
      STEP_CNT_H:  bus_wdata_o = len_hi;
      STEP_DATA:   bus_wdata_o = data_q;
      STEP_EXEC:   bus_wdata_o = BUS_W'(EXEC_VAL);
      default:     bus_wdata_o = '0;
    endcase
  end

  assign bus_addr_o  = ADDR_W'(step_off);
  assign bus_wr_o    = (state_q == ST_ISSUE) && !step_rd;
  assign bus_rd_o    = (state_q == ST_ISSUE) && step_rd;
  assign req_ready_o = (state_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      step_q     <= STEP_CODE;
      code_q     <= '0;
      addr_q     <= '0;
      len_q      <= '0;
      has_data_q <= 1'b0;
      data_q     <= '0;
      poll_cnt_q <= '0;
      done_q     <= 1'b0;
      fail_q     <= 1'b0;
      tmo_q      <= 1'b0;
      stat_q     <= '0;
      region_q   <= 2'd0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            code_q     <= req_code_i;
            addr_q     <= req_addr_i;
            len_q      <= req_len_i;
            has_data_q <= req_has_data_i;
            data_q     <= req_data_i;
            step_q     <= STEP_CODE;
            poll_cnt_q <= '0;
            state_q    <= ST_ISSUE;
          end
        end
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (bus_ack_i) begin
            if (step_q == STEP_POLL) begin
              if (st_ready || poll_cnt_q == POLL_LAST) begin
                done_q   <= 1'b1;
                tmo_q    <= !st_ready;
                fail_q   <= !st_ready || st_err;
                stat_q   <= bus_rdata_i;
                region_q <= st_region;
                state_q  <= ST_IDLE;
              end else begin
                poll_cnt_q <= poll_cnt_q + 1'b1;
                state_q    <= ST_ISSUE;
              end
            end else begin
              step_q  <= step_nxt;
              state_q <= ST_ISSUE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o    = done_q;
  assign fail_o    = fail_q;
  assign timeout_o = tmo_q;
  assign status_o  = stat_q;
  assign region_o  = region_q;

endmodule

// File: rtl/ovl_cmd_seq_chk.sv
module ovl_cmd_seq_chk #(
  parameter int BUS_W  = 16,
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              bus_wr_o,
  input logic              bus_rd_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [BUS_W-1:0]  bus_wdata_o,
  input logic              done_o,
  input logic              fail_o,
  input logic              timeout_o,
  input logic [BUS_W-1:0]  status_o
);

  // R7
  strobe_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_o || bus_rd_o) |=> !(bus_wr_o || bus_rd_o));

  // R7
  no_rd_wr_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_wr_o && bus_rd_o));

  // R5
  exec_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_o && bus_addr_o == ADDR_W'(8'hC0)) |-> bus_wdata_o == BUS_W'(1));

  // R8
  poll_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rd_o |-> bus_addr_o == ADDR_W'(8'hCC));

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  ready_on_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !timeout_o) |-> status_o[7]);

  // R11
  timeout_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && timeout_o) |-> (fail_o && !status_o[7]));

  // R12
  busy_only_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_o || bus_rd_o) |-> !req_ready_o);

endmodule

bind ovl_cmd_seq ovl_cmd_seq_chk #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .bus_wr_o    (bus_wr_o),
  .bus_rd_o    (bus_rd_o),
  .bus_addr_o  (bus_addr_o),
  .bus_wdata_o (bus_wdata_o),
  .done_o      (done_o),
  .fail_o      (fail_o),
  .timeout_o   (timeout_o),
  .status_o    (status_o)
);

// File: tb/ovl_cmd_seq_tb.sv
module ovl_cmd_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int BUS_W      = 16;
  localparam int ADDR_W     = 8;
  localparam int CMD_ADDR_W = 32;
  localparam int LEN_W      = 32;
  localparam int MAX_POLLS  = 6;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  req_valid = 1'b0;
  logic                  req_ready;
  logic [BUS_W-1:0]      req_code = '0;
  logic [CMD_ADDR_W-1:0] req_addr = '0;
  logic [LEN_W-1:0]      req_len = '0;
  logic                  req_has_data = 1'b0;
  logic [BUS_W-1:0]      req_data = '0;
  logic                  bus_wr, bus_rd;
  logic [ADDR_W-1:0]     bus_addr;
  logic [BUS_W-1:0]      bus_wdata;
  logic                  bus_ack = 1'b0;
  logic [BUS_W-1:0]      bus_rdata = '0;
  logic                  done, fail, tmo;
  logic [BUS_W-1:0]      status;
  logic [1:0]            region;

  int unsigned n_chk = 0;
  int unsigned n_fail = 0;

  ovl_cmd_seq #(
    .BUS_W(BUS_W), .ADDR_W(ADDR_W), .CMD_ADDR_W(CMD_ADDR_W),
    .LEN_W(LEN_W), .MAX_POLLS(MAX_POLLS)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_code_i(req_code), .req_addr_i(req_addr), .req_len_i(req_len),
    .req_has_data_i(req_has_data), .req_data_i(req_data),
    .bus_wr_o(bus_wr), .bus_rd_o(bus_rd), .bus_addr_o(bus_addr),
    .bus_wdata_o(bus_wdata), .bus_ack_i(bus_ack), .bus_rdata_i(bus_rdata),
    .done_o(done), .fail_o(fail), .timeout_o(tmo),
    .status_o(status), .region_o(region)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // device model
  int unsigned      wr_cnt = 0, rd_cnt = 0;
  logic [7:0]       log_a [256];
  logic [15:0]      log_d [256];
  bit               pend = 1'b0;
  int unsigned      dly = 0;
  int unsigned      overlap_err = 0, wide_err = 0;
  bit               prev_strobe = 1'b0;
  logic [15:0]      resp = '0;
  int unsigned      rd_base = 0, ready_after = 0;
  logic [15:0]      busy_w = '0, final_w = 16'h0080;

  always @(posedge clk) begin
    bus_ack <= 1'b0;
    prev_strobe <= bus_wr || bus_rd;
    if ((bus_wr || bus_rd) && prev_strobe) wide_err <= wide_err + 1;
    if ((bus_wr || bus_rd) && (bus_wr && bus_rd)) wide_err <= wide_err + 1;
    if (pend) begin
      if (dly == 0) begin
        bus_ack   <= 1'b1;
        bus_rdata <= resp;
        pend      <= 1'b0;
      end else dly <= dly - 1;
    end
    if (bus_wr || bus_rd) begin
      if (pend) overlap_err <= overlap_err + 1;
      pend <= 1'b1;
      dly  <= $urandom_range(2, 0);
      if (bus_wr) begin
        log_a[wr_cnt[7:0]] <= bus_addr;
        log_d[wr_cnt[7:0]] <= bus_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        resp   <= ((rd_cnt - rd_base) < ready_after) ? busy_w : final_w;
        rd_cnt <= rd_cnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_region(input logic [15:0] w);
    if (w[9] && w[8]) return 2'd3;
    if (w[9])         return 2'd2;
    if (w[8])         return 2'd1;
    return 2'd0;
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      8'h80:        return "R2";
      8'h88, 8'h8A: return "R6";
      8'h90, 8'h92: return "R3";
      8'h84:        return "R4";
      default:      return "R5";
    endcase
  endfunction

  task automatic run_cmd(input logic [15:0] code, input logic [31:0] addr,
                         input logic [31:0] len, input bit hd, input logic [15:0] dat,
                         input int unsigned ra, input logic [15:0] bw,
                         input logic [15:0] fw, input bit poke);
    logic [7:0]  ea [8];
    logic [15:0] ed [8];
    int          n = 0;
    int unsigned wbase;
    bit          exp_tmo;
    logic [15:0] exp_st;
    int          guard = 0;
    ea[n] = 8'h80; ed[n] = code;          n++;
    ea[n] = 8'h88; ed[n] = addr[15:0];    n++;
    ea[n] = 8'h8A; ed[n] = addr[31:16];   n++;
    if (len != 0) begin
      ea[n] = 8'h90; ed[n] = len[15:0];   n++;
      ea[n] = 8'h92; ed[n] = len[31:16];  n++;
    end
    if (hd) begin ea[n] = 8'h84; ed[n] = dat; n++; end
    ea[n] = 8'hC0; ed[n] = 16'h0001; n++;
    exp_tmo = (ra >= MAX_POLLS);
    exp_st  = exp_tmo ? bw : fw;

    while (!req_ready && guard < 5000) begin @(negedge clk); guard++; end
    rd_base = rd_cnt; ready_after = ra; busy_w = bw; final_w = fw;
    wbase = wr_cnt;
    req_code = code; req_addr = addr; req_len = len; req_has_data = hd; req_data = dat;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R12 busy after accept", req_ready, 0);
    if (poke) begin
      repeat (3) @(negedge clk);
      req_code = 16'hBEEF; req_valid = 1'b1;
      repeat (2) @(negedge clk);
      req_valid = 1'b0;
    end
    guard = 0;
    while (!done && guard < 5000) begin @(negedge clk); guard++; end
    chk(done == 1'b1, "R8 done seen (watchdog)", done, 1);
    chk(tmo == exp_tmo, exp_tmo ? "R11 timeout" : "R9 timeout clear", tmo, exp_tmo);
    chk(fail == (exp_tmo || |(fw & 16'h133A)), exp_tmo ? "R11 fail" : "R9 fail",
        fail, exp_tmo || |(fw & 16'h133A));
    chk(status == exp_st, exp_tmo ? "R11 status" : "R9 status", status, exp_st);
    chk(region == exp_region(exp_st), "R10 region", region, exp_region(exp_st));
    chk((rd_cnt - rd_base) == (exp_tmo ? MAX_POLLS : ra + 1), "R8 poll reads",
        rd_cnt - rd_base, exp_tmo ? MAX_POLLS : ra + 1);
    chk((wr_cnt - wbase) == n, "R3 R4 write count", wr_cnt - wbase, n);
    for (int i = 0; i < n; i++) begin
      chk(log_a[(wbase + i) % 256] == ea[i], tag_of(ea[i]), log_a[(wbase + i) % 256], ea[i]);
      chk(log_d[(wbase + i) % 256] == ed[i], tag_of(ea[i]), log_d[(wbase + i) % 256], ed[i]);
    end
    @(negedge clk);
    chk(done == 1'b0, "R8 single pulse", done, 0);
    if (poke) begin
      repeat (10) @(negedge clk);
      chk((wr_cnt - wbase) == n && req_ready, "R12 ignored request", wr_cnt - wbase, n);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_fail++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1
    chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
    chk(!bus_wr && !bus_rd, "R1 no strobe", {bus_wr, bus_rd}, 0);
    chk(done == 1'b0, "R1 done", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && !bus_wr && !bus_rd, "R1 idle after release", req_ready, 1);

    run_cmd(16'h0020, 32'h1234_5678, 32'h0,        1'b0, 16'h0,    0, 16'h0000, 16'h0080, 1'b0);
    run_cmd(16'h00E9, 32'hA5A5_0F0F, 32'h0000_0040, 1'b1, 16'hCAFE, 2, 16'h0002, 16'h8380, 1'b0);
    run_cmd(16'h0041, 32'h0000_FFFF, 32'h0,        1'b1, 16'h55AA, 1, 16'h0000, 16'h8280, 1'b0);
    run_cmd(16'h0061, 32'hFFFF_0000, 32'h0001_0000, 1'b0, 16'h0,    0, 16'h0000, 16'h8180, 1'b0);
    run_cmd(16'h0062, 32'h0,         32'hFFFF_FFFF, 1'b0, 16'h0,    0, 16'h0000, 16'hECC5, 1'b0);
    // R11 device stays busy past the limit
    run_cmd(16'h0098, 32'h0000_0100, 32'h0,        1'b0, 16'h0,    MAX_POLLS + 3, 16'h0300, 16'h0080, 1'b0);
    // one short of the limit still completes
    run_cmd(16'h0097, 32'h0000_0200, 32'h2,        1'b1, 16'h0001, MAX_POLLS - 1, 16'h0010, 16'h0480, 1'b0);
    // R12 request raised mid-command
    run_cmd(16'h00D0, 32'h0BAD_F00D, 32'h5,        1'b1, 16'h7777, 3, 16'h0000, 16'h8080, 1'b1);

    for (int k = 0; k < 30; k++) begin
      logic [31:0] l;
      l = ($urandom_range(2, 0) == 0) ? 32'h0 : $urandom;
      run_cmd(16'($urandom), $urandom, l, 1'($urandom), 16'($urandom),
              $urandom_range(MAX_POLLS + 1, 0), 16'($urandom) & 16'hFF7F,
              16'($urandom) | 16'h0080, 1'b0);
    end

    // R7
    chk(overlap_err == 0, "R7 strobe before ack", overlap_err, 0);
    chk(wide_err == 0, "R7 strobe width", wide_err, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule